// File: doc/BRIEF.md
# Dual-Slot Per-Warp Register Scoreboard

This block records which architectural registers have a write still in flight, for a configurable number of warps. Every warp keeps two independent reservation tables. Table 0 belongs to the primary half of the warp's instruction buffer, and table 1 belongs to the secondary half. Because each half owns its own lanes, a reservation carries no lane mask. A hazard exists only when an operand meets a reservation in the table the instruction is pinned to.

Issue logic states where an instruction came from. A primary issue uses table 0 of its own warp. An intra-warp co-issue uses table 1 of the primary warp. An inter-warp co-issued donor uses table 0 of the donor warp. Reservations land on the next clock edge.

Writeback frees one register per cycle in a named warp and table. When the writeback path has not recorded a table, the block picks one from the co-issue type. A combinational check compares all operands of a candidate instruction against one chosen table. Clean and pending flags let the fetch stage wait until a table has drained before it hands that buffer half to another split.

Top module: `dual_slot_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, every bit of `slot_clean` is 1 and every bit of `warp_pending` is 0.
- R2: The value on `rsv_kind` selects the table. Primary (0) and inter-warp donor (2) both select table 0 of `rsv_warp`. Intra-warp co-issue (1) selects table 1 of `rsv_warp`. Value 3 is illegal. Each nonzero entry of `rsv_dst` becomes reserved in the selected table, and the reservation is visible from the cycle after the clock edge.
- R3: A reservation is flat membership, not a count. Reserving a register that is already reserved keeps it reserved, and a single release clears it.
- R4: Releasing a register that is not reserved in the addressed table changes nothing.
- R5: A release with `rel_slot_vld`=1 targets table `rel_slot`. A release with `rel_slot_vld`=0 targets table 1 when `rel_intra`=1 and table 0 otherwise.
- R6: `chk_hazard` is combinational. It is 1 exactly when at least one nonzero operand is reserved in the selected table. The operands are the 2 destinations, 4 sources, the predicate and the 2 address registers. The table is chosen from `chk_warp` and from `chk_kind`, using the same mapping as R2. Operand i occupies bits [6i+5:6i] of its bus.
- R7: Tables are isolated. A reservation in one table never raises a hazard for a check against the other table of the same warp, or against any table of another warp.
- R8: `slot_clean[2w+s]` is 1 exactly when table s of warp w holds no reservation. `warp_pending[w]` is 1 unless both tables of warp w are clean.
- R9: A reserve and a release of the same register in the same warp and table, in the same cycle, leave the register reserved. A release of a different register in that same cycle still takes effect.
- R10: Register number 0 is never reserved and never causes a hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rsv_valid | input | 1 | Reserve request this cycle |
| rsv_warp | input | WID_W (2) | Warp receiving the reservation |
| rsv_kind | input | 2 | Issue origin: 0 primary, 1 intra co-issue, 2 inter donor |
| rsv_dst | input | NUM_DST*REG_W (12) | Destination registers, 0 means unused |
| rel_valid | input | 1 | Release request this cycle |
| rel_warp | input | WID_W (2) | Warp of the register to free |
| rel_reg | input | REG_W (6) | Register to free |
| rel_slot_vld | input | 1 | `rel_slot` holds a recorded table |
| rel_slot | input | 1 | Recorded table index |
| rel_intra | input | 1 | Release belongs to an intra-warp co-issue (used for the default) |
| chk_warp | input | WID_W (2) | Warp to check |
| chk_kind | input | 2 | Issue origin of the candidate; selects the table |
| chk_dst | input | NUM_DST*REG_W (12) | Candidate destinations |
| chk_src | input | NUM_SRC*REG_W (24) | Candidate sources |
| chk_pred | input | REG_W (6) | Candidate predicate register |
| chk_addr | input | 2*REG_W (12) | Candidate address registers |
| chk_hazard | output | 1 | Collision with the selected table |
| slot_clean | output | 2*NUM_WARPS (8) | Per-table empty flags, index 2w+s |
| warp_pending | output | NUM_WARPS (4) | Warp has any reservation in either table |

## Verification
Two functions can act in the same cycle: a reserve from the issue side and a release from the writeback side. The bench provokes this by driving both requests in one clock cycle. In one case both name the same warp, table and register. In the other they name different registers in the same table. The outcome is judged afterwards through the hazard check and the clean flags. The shared register must still collide. The other released register must be gone, and the newly reserved register must be present.

// File: rtl/sb_pkg.sv
// Package: shared encodings for the dual-slot scoreboard.
// Assumes: exactly two tables per warp, one per instruction-buffer half.
package sb_pkg;
    localparam int TABLES_PER_WARP = 2;

    typedef enum logic [1:0] {
        ORIGIN_PRIMARY = 2'd0,
        ORIGIN_INTRA   = 2'd1,
        ORIGIN_DONOR   = 2'd2,
        ORIGIN_ILLEGAL = 2'd3
    } issue_origin_e;

    // Table pinned to an issue origin: only intra co-issue uses table 1.
    function automatic logic table_of_origin(input issue_origin_e origin);
        return (origin == ORIGIN_INTRA);
    endfunction
endpackage

// File: rtl/sb_slot_router.sv
// Module: sb_slot_router
// Resolves which table each request targets. Reserve and check use the
// issue origin. A release uses the recorded table when present, or else
// falls back to the co-issue type.
// Assumes: origin code 3 never arrives with a valid reserve.
module sb_slot_router
    import sb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rsv_valid,
    input  logic [1:0] rsv_kind,
    input  logic [1:0] chk_kind,
    input  logic       rel_slot_vld,
    input  logic       rel_slot,
    input  logic       rel_intra,
    output logic       rsv_tbl,
    output logic       chk_tbl,
    output logic       rel_tbl
);
    issue_origin_e rsv_origin;
    issue_origin_e chk_origin;

    // Decode origins into their table index.
    always_comb begin
        rsv_origin = issue_origin_e'(rsv_kind);
        chk_origin = issue_origin_e'(chk_kind);
        rsv_tbl    = table_of_origin(rsv_origin);
        chk_tbl    = table_of_origin(chk_origin);
    end

    // Pick the release table: recorded index first, otherwise by co-issue type.
    always_comb begin
        if (rel_slot_vld) rel_tbl = rel_slot;
        else              rel_tbl = rel_intra;
    end

    // An illegal origin may not accompany a reserve request.
    assert_no_illegal_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid |-> (rsv_kind != 2'd3));
endmodule

// File: rtl/sb_table.sv
// Module: sb_table
// One reservation table: a register bitvector with multi-port set and
// single-port clear. A set wins over a clear of the same bit. Register 0
// is never stored.
// Assumes: set and clear registers are below NUM_REGS.
module sb_table #(
    parameter int NUM_REGS = 64,
    parameter int NUM_DST  = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [NUM_DST*REG_W-1:0] set_regs,
    input  logic                     clr_en,
    input  logic [REG_W-1:0]         clr_reg,
    output logic [NUM_REGS-1:0]      bits,
    output logic                     clean
);
    logic [NUM_REGS-1:0] set_mask;
    logic [NUM_REGS-1:0] clr_mask;
    logic [NUM_REGS-1:0] bits_next;

    // Build the one-hot set mask from every nonzero destination.
    always_comb begin
        set_mask = '0;
        if (set_en) begin
            for (int d = 0; d < NUM_DST; d++) begin
                if (set_regs[d*REG_W +: REG_W] != '0)
                    set_mask[set_regs[d*REG_W +: REG_W]] = 1'b1;
            end
        end
    end

    // Build the one-hot clear mask from a nonzero release register.
    always_comb begin
        clr_mask = '0;
        if (clr_en && clr_reg != '0) clr_mask[clr_reg] = 1'b1;
    end

    // Next state: clear first, then set, so a set overrides a clear.
    always_comb bits_next = (bits & ~clr_mask) | set_mask;

    // Table register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= bits_next;
    end

    // Empty flag for the table.
    always_comb clean = (bits == '0);

    // Every reserved destination is present after the edge.
    for (genvar d = 0; d < NUM_DST; d++) begin : g_set_chk
        assert_reserve_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && set_regs[d*REG_W +: REG_W] != '0)
                |=> bits[$past(set_regs[d*REG_W +: REG_W])]);
    end

    // A release not hit by a same-cycle set empties its bit.
    assert_release_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_reg != '0 && !set_mask[clr_reg]) |=> !bits[$past(clr_reg)]);

    // Same-register reserve and release: the bit stays set.
    assert_reserve_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_reg != '0 && set_mask[clr_reg]) |=> bits[$past(clr_reg)]);

    // Bits outside both masks hold, so an unmatched release changes nothing.
    assert_untouched_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((bits ^ $past(bits)) & ~$past(set_mask | clr_mask)) == '0));

    // Register 0 is never held.
    assert_reg0_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bits[0]);
endmodule

// File: rtl/sb_hazard.sv
// Module: sb_hazard
// Combinational collision check of a packed operand list against one
// selected table.
// Assumes: table index is warp*2+table; an index past NUM_TABLES gives no hazard.
module sb_hazard #(
    parameter int NUM_TABLES = 8,
    parameter int NUM_REGS   = 64,
    parameter int NUM_OPS    = 9,
    parameter int IDX_W      = 3,
    localparam int REG_W     = $clog2(NUM_REGS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_TABLES-1:0][NUM_REGS-1:0]  tables,
    input  logic [IDX_W-1:0]                     sel,
    input  logic [NUM_OPS*REG_W-1:0]             ops,
    output logic                                 hazard
);
    logic [NUM_REGS-1:0] row;
    logic [NUM_OPS-1:0]  op_hit;
    logic                any_op;

    // Select the addressed table.
    always_comb begin
        row = '0;
        for (int t = 0; t < NUM_TABLES; t++) begin
            if (sel == IDX_W'(t)) row = tables[t];
        end
    end

    // Test each nonzero operand against the selected table.
    always_comb begin
        any_op = 1'b0;
        for (int i = 0; i < NUM_OPS; i++) begin
            op_hit[i] = (ops[i*REG_W +: REG_W] != '0) && row[ops[i*REG_W +: REG_W]];
            any_op    = any_op | (ops[i*REG_W +: REG_W] != '0);
        end
        hazard = |op_hit;
    end

    // A hazard needs at least one live operand; all-zero operands never collide.
    assert_zero_operands_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> any_op);
endmodule

// File: rtl/dual_slot_scoreboard.sv
// Module: dual_slot_scoreboard (top)
// Per-warp pending-write tracking with two tables per warp, pinned to
// the two instruction-buffer halves. It has one reserve port, one release
// port, a combinational hazard check and clean/pending status.
// Assumes: at most one reserve and one release per cycle; registers are
// REG_W bits wide and value 0 means "no register".
module dual_slot_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int NUM_REGS  = 64,
    parameter int NUM_DST   = 2,
    parameter int NUM_SRC   = 4,
    localparam int REG_W      = $clog2(NUM_REGS),
    localparam int WID_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int NUM_TABLES = NUM_WARPS * TABLES_PER_WARP,
    localparam int IDX_W      = WID_W + 1,
    localparam int NUM_OPS    = NUM_DST + NUM_SRC + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rsv_valid,
    input  logic [WID_W-1:0]         rsv_warp,
    input  logic [1:0]               rsv_kind,
    input  logic [NUM_DST*REG_W-1:0] rsv_dst,
    input  logic                     rel_valid,
    input  logic [WID_W-1:0]         rel_warp,
    input  logic [REG_W-1:0]         rel_reg,
    input  logic                     rel_slot_vld,
    input  logic                     rel_slot,
    input  logic                     rel_intra,
    input  logic [WID_W-1:0]         chk_warp,
    input  logic [1:0]               chk_kind,
    input  logic [NUM_DST*REG_W-1:0] chk_dst,
    input  logic [NUM_SRC*REG_W-1:0] chk_src,
    input  logic [REG_W-1:0]         chk_pred,
    input  logic [2*REG_W-1:0]       chk_addr,
    output logic                     chk_hazard,
    output logic [NUM_TABLES-1:0]    slot_clean,
    output logic [NUM_WARPS-1:0]     warp_pending
);
    logic rsv_tbl;
    logic chk_tbl;
    logic rel_tbl;
    logic [NUM_TABLES-1:0][NUM_REGS-1:0] tables;
    logic [IDX_W-1:0]         chk_sel;
    logic [NUM_OPS*REG_W-1:0] chk_ops;

    sb_slot_router u_router (
        .clk          (clk),
        .rst_n        (rst_n),
        .rsv_valid    (rsv_valid),
        .rsv_kind     (rsv_kind),
        .chk_kind     (chk_kind),
        .rel_slot_vld (rel_slot_vld),
        .rel_slot     (rel_slot),
        .rel_intra    (rel_intra),
        .rsv_tbl      (rsv_tbl),
        .chk_tbl      (chk_tbl),
        .rel_tbl      (rel_tbl)
    );

    // One table per warp and buffer half.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        for (genvar s = 0; s < TABLES_PER_WARP; s++) begin : g_tbl
            logic set_hit;
            logic clr_hit;

            // Address decode of the reserve and release ports for this table.
            always_comb begin
                set_hit = rsv_valid && (rsv_warp == WID_W'(w)) && (rsv_tbl == 1'(s));
                clr_hit = rel_valid && (rel_warp == WID_W'(w)) && (rel_tbl == 1'(s));
            end

            sb_table #(
                .NUM_REGS (NUM_REGS),
                .NUM_DST  (NUM_DST)
            ) u_table (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_en   (set_hit),
                .set_regs (rsv_dst),
                .clr_en   (clr_hit),
                .clr_reg  (rel_reg),
                .bits     (tables[w*TABLES_PER_WARP + s]),
                .clean    (slot_clean[w*TABLES_PER_WARP + s])
            );
        end

        // Warp has pending writes unless both of its tables are empty.
        always_comb warp_pending[w] = !(slot_clean[w*TABLES_PER_WARP] &&
                                        slot_clean[w*TABLES_PER_WARP + 1]);
    end

    // Pack the check operands: destinations, sources, predicate, addresses.
    always_comb begin
        chk_ops = {chk_addr, chk_pred, chk_src, chk_dst};
        chk_sel = {chk_warp, chk_tbl};
    end

    sb_hazard #(
        .NUM_TABLES (NUM_TABLES),
        .NUM_REGS   (NUM_REGS),
        .NUM_OPS    (NUM_OPS),
        .IDX_W      (IDX_W)
    ) u_hazard (
        .clk    (clk),
        .rst_n  (rst_n),
        .tables (tables),
        .sel    (chk_sel),
        .ops    (chk_ops),
        .hazard (chk_hazard)
    );

    // A collision can only come from a table that is not clean.
    assert_hazard_needs_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hazard |-> !slot_clean[chk_sel]);

    // An intra co-issue reservation makes table 1 of that warp non-clean.
    assert_intra_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && rsv_kind == 2'd1 && rsv_dst[REG_W-1:0] != '0)
            |=> !slot_clean[$past(rsv_warp)*2 + 1]);
endmodule

// File: tb/tb_dual_slot_scoreboard.sv
module tb_dual_slot_scoreboard;
    localparam int NW = 4;
    localparam int RW = 6;
    localparam int WW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rsv_valid = 0; logic [WW-1:0] rsv_warp = 0; logic [1:0] rsv_kind = 0;
    logic [2*RW-1:0] rsv_dst = 0;
    logic rel_valid = 0; logic [WW-1:0] rel_warp = 0; logic [RW-1:0] rel_reg = 0;
    logic rel_slot_vld = 0; logic rel_slot = 0; logic rel_intra = 0;
    logic [WW-1:0] chk_warp = 0; logic [1:0] chk_kind = 0;
    logic [2*RW-1:0] chk_dst = 0; logic [4*RW-1:0] chk_src = 0;
    logic [RW-1:0] chk_pred = 0; logic [2*RW-1:0] chk_addr = 0;
    logic chk_hazard;
    logic [2*NW-1:0] slot_clean;
    logic [NW-1:0] warp_pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_slot_scoreboard dut (
        .clk(clk), .rst_n(rst_n),
        .rsv_valid(rsv_valid), .rsv_warp(rsv_warp), .rsv_kind(rsv_kind), .rsv_dst(rsv_dst),
        .rel_valid(rel_valid), .rel_warp(rel_warp), .rel_reg(rel_reg),
        .rel_slot_vld(rel_slot_vld), .rel_slot(rel_slot), .rel_intra(rel_intra),
        .chk_warp(chk_warp), .chk_kind(chk_kind), .chk_dst(chk_dst), .chk_src(chk_src),
        .chk_pred(chk_pred), .chk_addr(chk_addr),
        .chk_hazard(chk_hazard), .slot_clean(slot_clean), .warp_pending(warp_pending)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change 1 ns after it.
    task automatic step();
        @(posedge clk); #1;
        rsv_valid = 0; rel_valid = 0;
    endtask

    task automatic set_rsv(input int w, input int kind, input int d0, input int d1);
        rsv_valid = 1; rsv_warp = WW'(w); rsv_kind = 2'(kind);
        rsv_dst = {RW'(d1), RW'(d0)};
    endtask

    task automatic set_rel(input int w, input int r, input bit svld, input bit s, input bit intra);
        rel_valid = 1; rel_warp = WW'(w); rel_reg = RW'(r);
        rel_slot_vld = svld; rel_slot = s; rel_intra = intra;
    endtask

    // Put register r in operand position pos (0-1 dst, 2-5 src, 6 pred, 7-8 addr) and sample.
    task automatic query(input int w, input int kind, input int pos, input int r, output logic h);
        @(negedge clk);
        chk_warp = WW'(w); chk_kind = 2'(kind);
        chk_dst = 0; chk_src = 0; chk_pred = 0; chk_addr = 0;
        if (pos < 2)       chk_dst[pos*RW +: RW] = RW'(r);
        else if (pos < 6)  chk_src[(pos-2)*RW +: RW] = RW'(r);
        else if (pos == 6) chk_pred = RW'(r);
        else               chk_addr[(pos-7)*RW +: RW] = RW'(r);
        #1 h = chk_hazard;
    endtask

    task automatic t_reset();
        check("R1 clean after reset", 32'(slot_clean), 32'hFF);
        check("R1 pending after reset", 32'(warp_pending), 32'h0);
    endtask

    task automatic t_mapping();
        logic h;
        set_rsv(1, 0, 5, 0); step();
        check("R2 primary to table 0", 32'(slot_clean), 32'hFB);
        query(1, 0, 2, 5, h); check("R2 primary check hits", 32'(h), 1);
        query(1, 1, 2, 5, h); check("R7 other table quiet", 32'(h), 0);
        query(0, 0, 2, 5, h); check("R7 other warp quiet", 32'(h), 0);
        set_rsv(2, 1, 9, 0); step();
        check("R2 intra to table 1", 32'(slot_clean), 32'hDB);
        set_rsv(3, 2, 12, 0); step();
        check("R2 donor to table 0", 32'(slot_clean), 32'h9B);
        check("R8 warp pending", 32'(warp_pending), 32'hE);
        set_rel(1, 5, 1, 0, 0); step();
        check("R5 recorded table", 32'(slot_clean), 32'h9F);
        set_rel(2, 9, 0, 0, 1); step();
        check("R5 intra default table 1", 32'(slot_clean), 32'hBF);
        set_rel(3, 12, 0, 1, 0); step();
        check("R5 default table 0", 32'(slot_clean), 32'hFF);
        check("R8 nothing pending", 32'(warp_pending), 32'h0);
    endtask

    task automatic t_flat();
        set_rsv(0, 0, 7, 7); step();
        set_rsv(0, 0, 7, 0); step();
        check("R3 reserved", 32'(slot_clean[0]), 0);
        set_rel(0, 7, 1, 0, 0); step();
        check("R3 one release clears", 32'(slot_clean[0]), 1);
    endtask

    task automatic t_noeffect();
        logic h;
        set_rsv(0, 0, 3, 0); step();
        set_rel(0, 4, 1, 0, 0); step();
        set_rel(0, 3, 1, 1, 0); step();
        query(0, 0, 3, 3, h); check("R4 stray release no effect", 32'(h), 1);
        check("R4 table 1 still clean", 32'(slot_clean[1]), 1);
        set_rel(0, 3, 1, 0, 0); step();
        check("R4 cleanup", 32'(slot_clean[0]), 1);
    endtask

    task automatic t_hazard();
        logic h;
        set_rsv(0, 2, 20, 0); step();
        for (int p = 0; p < 9; p++) begin
            query(0, 0, p, 20, h); check($sformatf("R6 operand %0d hit", p), 32'(h), 1);
        end
        query(0, 0, 4, 21, h); check("R6 other register quiet", 32'(h), 0);
        query(0, 0, 0, 0, h);  check("R10 zero operands quiet", 32'(h), 0);
        query(1, 0, 4, 20, h); check("R7 warp isolation", 32'(h), 0);
        set_rel(0, 20, 1, 0, 0); step();
        set_rsv(1, 1, 0, 0); step();
        check("R10 register 0 not held", 32'(slot_clean), 32'hFF);
    endtask

    task automatic t_collide();
        logic h;
        set_rsv(0, 0, 30, 0); step();
        set_rsv(0, 0, 30, 0); set_rel(0, 30, 1, 0, 0); step();
        query(0, 0, 2, 30, h); check("R9 reserve wins", 32'(h), 1);
        set_rsv(0, 0, 31, 0); set_rel(0, 30, 1, 0, 0); step();
        query(0, 0, 2, 30, h); check("R9 other release applies", 32'(h), 0);
        query(0, 0, 2, 31, h); check("R9 new reserve present", 32'(h), 1);
        set_rel(0, 31, 1, 0, 0); step();
        check("R9 drained", 32'(slot_clean), 32'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        rst_n = 1;
        step();
        t_reset();
        t_mapping();
        t_flat();
        t_noeffect();
        t_hazard();
        t_collide();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule